// File: doc/BRIEF.md
# Two-Port Synchronous RAM with Per-Port Burst Address Counters

The block is a shared word array reached from two fully independent ports, called left and right, each with its own clock and reset. On every rising edge of its clock, a port chooses one access address. It takes that address either from its address input, when the strobe is low, or from its own burst counter. The counter can be cleared, loaded, stepped by one or held. A selected port either writes its input word into the array or reads a word out. The read word reaches the port's output after one edge in flow-through mode, or after two edges in pipelined mode. A mode input picks between the two at run time.

Each port's counter works as a four-state machine. The states are CNT_CLEAR, CNT_LOAD, CNT_STEP and CNT_HOLD, and they are re-chosen at every edge with a fixed priority. The edge leads to CNT_CLEAR when the counter-reset input is low. Otherwise it leads to CNT_LOAD when the strobe is low, then to CNT_STEP when the counter-enable input is low, and otherwise to CNT_HOLD. The access address at an edge is always the value the counter takes at that edge. A burst is therefore started with a load and continued with steps, and the counter wraps from the top address to zero.

The address width is a parameter. Widths of 15, 16 and 17 bits give 32K, 64K and 128K words. The data width is 8 or 9 bits. The data bus is modelled as a separate input word and output word, together with an output-valid flag.

Top module: `dpram_burst`

## Requirements
- R1: A port is selected at an edge only when its ce0_n input is 0 and its ce1 input is 1. At any other combination that edge writes nothing and produces no valid read.
- R2: When ads_n is 0 at an edge and cntrst_n is 1, the access uses the address input, and the counter takes that address.
- R3: When cntrst_n and ads_n are 1 and cnten_n is 0 at an edge, the counter advances by one, wrapping from 2^ADDR_W-1 to 0, and the access uses the advanced value.
- R4: When cntrst_n is 0 at an edge, the counter becomes 0 and the access uses address 0, whatever ads_n and cnten_n are.
- R5: When cntrst_n, ads_n and cnten_n are all 1 at an edge, the counter keeps its value and the access uses that value.
- R6: At a selected edge, rw_n = 0 writes the input word to the access address, and rw_n = 1 reads the word at that address.
- R7: rvalid is 1 only while oe_n is 0, and rdata is 0 whenever rvalid is 0. oe_n acts on the outputs at once, without waiting for a clock edge.
- R8: With pipe_sel = 0, a read's word and rvalid appear right after its edge and last one cycle. With pipe_sel = 1, they appear one edge later.
- R9: A word written by one port is returned by a read on the other port at any later edge.
- R10: A deselected port's counter still obeys cntrst_n, ads_n and cnten_n.
- R11: After reset, rvalid is 0 on both ports and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_l | input | 1 | Left port clock |
| rst_l_n | input | 1 | Left port reset, active low |
| addr_l | input | ADDR_W | Left external address |
| ads_l_n | input | 1 | Left address strobe, active low |
| ce0_l_n | input | 1 | Left chip enable, active low |
| ce1_l | input | 1 | Left chip enable, active high |
| rw_l_n | input | 1 | Left write when 0, read when 1 |
| oe_l_n | input | 1 | Left output enable, active low |
| pipe_l | input | 1 | Left read mode: 0 flow-through, 1 pipelined |
| cnten_l_n | input | 1 | Left counter step, active low |
| cntrst_l_n | input | 1 | Left counter clear, active low |
| wdata_l | input | DATA_W | Left write word |
| rdata_l | output | DATA_W | Left read word |
| rvalid_l | output | 1 | Left read word valid |
| clk_r | input | 1 | Right port clock |
| rst_r_n | input | 1 | Right port reset, active low |
| addr_r | input | ADDR_W | Right external address |
| ads_r_n | input | 1 | Right address strobe, active low |
| ce0_r_n | input | 1 | Right chip enable, active low |
| ce1_r | input | 1 | Right chip enable, active high |
| rw_r_n | input | 1 | Right write when 0, read when 1 |
| oe_r_n | input | 1 | Right output enable, active low |
| pipe_r | input | 1 | Right read mode: 0 flow-through, 1 pipelined |
| cnten_r_n | input | 1 | Right counter step, active low |
| cntrst_r_n | input | 1 | Right counter clear, active low |
| wdata_r | input | DATA_W | Right write word |
| rdata_r | output | DATA_W | Right read word |
| rvalid_r | output | 1 | Right read word valid |

## Verification
The bench builds the block with ADDR_W = 4 and DATA_W = 9. The 16-word array makes the wrap from address 15 to 0 reachable in a two-step burst, and a 9-bit word tests the full data width. Both port clocks are driven from one clock, so a write on one port and a read on the other fall on known, ordered edges. Under that arrangement, cross-port reads and reads at the same edge on both ports can be checked exactly.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    typedef enum logic [1:0] {
        CNT_HOLD,
        CNT_STEP,
        CNT_LOAD,
        CNT_CLEAR
    } cnt_op_e;

    // Fixed priority: clear, then load, then step, otherwise hold.
    function automatic cnt_op_e pick_op(input logic cntrst_n,
                                        input logic ads_n,
                                        input logic cnten_n);
        if (!cntrst_n)     return CNT_CLEAR;
        else if (!ads_n)   return CNT_LOAD;
        else if (!cnten_n) return CNT_STEP;
        else               return CNT_HOLD;
    endfunction

endpackage

// File: rtl/dpram_store.sv
module dpram_store #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 9,
    parameter bit FLIP   = 1'b0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [ADDR_W-1:0]           waddr,
    input  logic [DATA_W-1:0]           wdata,
    input  logic                        peer_tog,
    input  logic [1:0][ADDR_W-1:0]      rd_addr,
    output logic [1:0][DATA_W-1:0]      rd_data,
    output logic [1:0]                  rd_tog
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic              tog [DEPTH];

    // A write marks this copy as the newest one for its word by setting
    // its ownership bit relative to the peer copy's bit.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
            tog[waddr] <= peer_tog ^ FLIP;
        end
    end

    for (genvar p = 0; p < 2; p++) begin : g_rd
        assign rd_data[p] = mem[rd_addr[p]];
        assign rd_tog[p]  = tog[rd_addr[p]];
    end

    // R6
    store_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/dpram_port.sv
module dpram_port
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              ads_n,
    input  logic              ce0_n,
    input  logic              ce1,
    input  logic              rw_n,
    input  logic              oe_n,
    input  logic              pipe_sel,
    input  logic              cnten_n,
    input  logic              cntrst_n,
    input  logic [DATA_W-1:0] mem_rd,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              wr_en,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    cnt_op_e           op;
    logic [ADDR_W-1:0] cnt_q;
    logic [ADDR_W-1:0] cnt_nxt;
    logic              sel;
    logic              rd_en;
    logic              s1_v, s2_v;
    logic [DATA_W-1:0] s1_d, s2_d;
    logic              out_v;
    logic [DATA_W-1:0] out_d;

    always_comb op = pick_op(cntrst_n, ads_n, cnten_n);

    always_comb begin
        unique case (op)
            CNT_CLEAR: cnt_nxt = '0;
            CNT_LOAD:  cnt_nxt = ext_addr;
            CNT_STEP:  cnt_nxt = cnt_q + 1'b1;
            CNT_HOLD:  cnt_nxt = cnt_q;
            default:   cnt_nxt = cnt_q;
        endcase
    end

    // Counter state register: it follows its inputs whether or not the port is selected.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nxt;
    end

    assign acc_addr = cnt_nxt;
    assign sel      = !ce0_n && ce1;
    assign wr_en    = sel && !rw_n;
    assign rd_en    = sel && rw_n;

    // Read stages: stage 1 serves flow-through, stage 2 serves pipelined.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_v <= 1'b0;
            s2_v <= 1'b0;
            s1_d <= '0;
            s2_d <= '0;
        end else begin
            s1_v <= rd_en;
            s2_v <= s1_v;
            if (rd_en) s1_d <= mem_rd;
            s2_d <= s1_d;
        end
    end

    // Output process
    always_comb begin
        out_v  = pipe_sel ? s2_v : s1_v;
        out_d  = pipe_sel ? s2_d : s1_d;
        rvalid = out_v && !oe_n;
        rdata  = rvalid ? out_d : '0;
    end

    // R4
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cntrst_n |=> (cnt_q == '0));

    // R2
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cntrst_n && !ads_n) |=> (cnt_q == $past(ext_addr)));

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cntrst_n && ads_n && !cnten_n) |=> (cnt_q == ADDR_W'($past(cnt_q) + 1'b1)));

    // R5
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cntrst_n && ads_n && cnten_n) |=> $stable(cnt_q));

    // R7
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> !oe_n);

    // R1
    desel_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(!ce0_n && ce1) && !pipe_sel) |=> (!pipe_sel |-> !rvalid));

endmodule

// File: rtl/dpram_burst.sv
module dpram_burst #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 9
) (
    input  logic              clk_l,
    input  logic              rst_l_n,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic              ads_l_n,
    input  logic              ce0_l_n,
    input  logic              ce1_l,
    input  logic              rw_l_n,
    input  logic              oe_l_n,
    input  logic              pipe_l,
    input  logic              cnten_l_n,
    input  logic              cntrst_l_n,
    input  logic [DATA_W-1:0] wdata_l,
    output logic [DATA_W-1:0] rdata_l,
    output logic              rvalid_l,
    input  logic              clk_r,
    input  logic              rst_r_n,
    input  logic [ADDR_W-1:0] addr_r,
    input  logic              ads_r_n,
    input  logic              ce0_r_n,
    input  logic              ce1_r,
    input  logic              rw_r_n,
    input  logic              oe_r_n,
    input  logic              pipe_r,
    input  logic              cnten_r_n,
    input  logic              cntrst_r_n,
    input  logic [DATA_W-1:0] wdata_r,
    output logic [DATA_W-1:0] rdata_r,
    output logic              rvalid_r
);
    localparam int SIDES = 2;

    logic [SIDES-1:0]             clk_v, rst_v, ads_v, ce0_v, ce1_v, rw_v;
    logic [SIDES-1:0]             oe_v, pipe_v, cen_v, crst_v, we_v, rvalid_v;
    logic [SIDES-1:0][ADDR_W-1:0] addr_v, acc_v;
    logic [SIDES-1:0][DATA_W-1:0] wdata_v, rdata_v, res_v;
    logic [SIDES-1:0][DATA_W-1:0] rdq [SIDES];
    logic [SIDES-1:0]             tgq [SIDES];

    assign clk_v   = {clk_r, clk_l};
    assign rst_v   = {rst_r_n, rst_l_n};
    assign addr_v  = {addr_r, addr_l};
    assign ads_v   = {ads_r_n, ads_l_n};
    assign ce0_v   = {ce0_r_n, ce0_l_n};
    assign ce1_v   = {ce1_r, ce1_l};
    assign rw_v    = {rw_r_n, rw_l_n};
    assign oe_v    = {oe_r_n, oe_l_n};
    assign pipe_v  = {pipe_r, pipe_l};
    assign cen_v   = {cnten_r_n, cnten_l_n};
    assign crst_v  = {cntrst_r_n, cntrst_l_n};
    assign wdata_v = {wdata_r, wdata_l};

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        dpram_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
            .clk      (clk_v[s]),
            .rst_n    (rst_v[s]),
            .ext_addr (addr_v[s]),
            .ads_n    (ads_v[s]),
            .ce0_n    (ce0_v[s]),
            .ce1      (ce1_v[s]),
            .rw_n     (rw_v[s]),
            .oe_n     (oe_v[s]),
            .pipe_sel (pipe_v[s]),
            .cnten_n  (cen_v[s]),
            .cntrst_n (crst_v[s]),
            .mem_rd   (res_v[s]),
            .acc_addr (acc_v[s]),
            .wr_en    (we_v[s]),
            .rdata    (rdata_v[s]),
            .rvalid   (rvalid_v[s])
        );

        dpram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLIP(s != 0)) u_store (
            .clk      (clk_v[s]),
            .rst_n    (rst_v[s]),
            .we       (we_v[s]),
            .waddr    (acc_v[s]),
            .wdata    (wdata_v[s]),
            .peer_tog (tgq[SIDES-1-s][s]),
            .rd_addr  (acc_v),
            .rd_data  (rdq[s]),
            .rd_tog   (tgq[s])
        );

        // Equal ownership bits mean the left copy holds the newest word.
        assign res_v[s] = (tgq[0][s] == tgq[1][s]) ? rdq[0][s] : rdq[1][s];
    end

    assign rdata_l  = rdata_v[0];
    assign rvalid_l = rvalid_v[0];
    assign rdata_r  = rdata_v[1];
    assign rvalid_r = rvalid_v[1];

endmodule

// File: tb/dpram_burst_test.sv
`timescale 1ns/1ps
module dpram_burst_test;
    localparam int AW = 4;
    localparam int DW = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [AW-1:0] addr_l, addr_r;
    logic ads_l_n, ce0_l_n, ce1_l, rw_l_n, oe_l_n, pipe_l, cnten_l_n, cntrst_l_n;
    logic ads_r_n, ce0_r_n, ce1_r, rw_r_n, oe_r_n, pipe_r, cnten_r_n, cntrst_r_n;
    logic [DW-1:0] wdata_l, wdata_r, rdata_l, rdata_r;
    logic rvalid_l, rvalid_r;

    dpram_burst #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk_l(clk), .rst_l_n(rst_n), .addr_l(addr_l), .ads_l_n(ads_l_n),
        .ce0_l_n(ce0_l_n), .ce1_l(ce1_l), .rw_l_n(rw_l_n), .oe_l_n(oe_l_n),
        .pipe_l(pipe_l), .cnten_l_n(cnten_l_n), .cntrst_l_n(cntrst_l_n),
        .wdata_l(wdata_l), .rdata_l(rdata_l), .rvalid_l(rvalid_l),
        .clk_r(clk), .rst_r_n(rst_n), .addr_r(addr_r), .ads_r_n(ads_r_n),
        .ce0_r_n(ce0_r_n), .ce1_r(ce1_r), .rw_r_n(rw_r_n), .oe_r_n(oe_r_n),
        .pipe_r(pipe_r), .cnten_r_n(cnten_r_n), .cntrst_r_n(cntrst_r_n),
        .wdata_r(wdata_r), .rdata_r(rdata_r), .rvalid_r(rvalid_r)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [DW-1:0] shadow [1 << AW];
    logic [AW-1:0] cnt_m [2];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_side(input int side, input logic ce0n, input logic ce1v,
                            input logic ads, input logic cen, input logic crst,
                            input logic rw, input logic [AW-1:0] a, input logic [DW-1:0] d,
                            output logic [AW-1:0] acc);
        // Bench model of the counter priority and access address (R2..R5).
        if (!crst)     acc = '0;
        else if (!ads) acc = a;
        else if (!cen) acc = cnt_m[side] + 1'b1;
        else           acc = cnt_m[side];
        cnt_m[side] = acc;
        if (!ce0n && ce1v && !rw) shadow[acc] = d;
        if (side == 0) begin
            ce0_l_n = ce0n; ce1_l = ce1v; ads_l_n = ads; cnten_l_n = cen;
            cntrst_l_n = crst; rw_l_n = rw; addr_l = a; wdata_l = d;
        end else begin
            ce0_r_n = ce0n; ce1_r = ce1v; ads_r_n = ads; cnten_r_n = cen;
            cntrst_r_n = crst; rw_r_n = rw; addr_r = a; wdata_r = d;
        end
    endtask

    task automatic idle_all();
        ce0_l_n = 1; ce1_l = 0; ads_l_n = 1; cnten_l_n = 1; cntrst_l_n = 1; rw_l_n = 1;
        ce0_r_n = 1; ce1_r = 0; ads_r_n = 1; cnten_r_n = 1; cntrst_r_n = 1; rw_r_n = 1;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle_all();
    endtask

    task automatic op(input int side, input logic ce0n, input logic ce1v,
                      input logic ads, input logic cen, input logic crst,
                      input logic rw, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      output logic [AW-1:0] acc);
        set_side(side, ce0n, ce1v, ads, cen, crst, rw, a, d, acc);
        tick();
    endtask

    task automatic wr_load(input int side, input logic [AW-1:0] a, input logic [DW-1:0] d);
        logic [AW-1:0] acc;
        op(side, 0, 1, 0, 1, 1, 0, a, d, acc);
    endtask

    task automatic rd_load(input int side, input logic [AW-1:0] a, input string req);
        logic [AW-1:0] acc;
        op(side, 0, 1, 0, 1, 1, 1, a, '0, acc);
        if (side == 0) begin
            chk(req, rvalid_l, 1);
            chk(req, rdata_l, shadow[acc]);
        end else begin
            chk(req, rvalid_r, 1);
            chk(req, rdata_r, shadow[acc]);
        end
    endtask

    task automatic t_reset();
        logic [AW-1:0] acc;
        chk("R11 rvalid_l after reset", rvalid_l, 0);
        chk("R11 rvalid_r after reset", rvalid_r, 0);
        op(0, 0, 1, 1, 1, 1, 0, 4'd7, 9'h055, acc);   // hold write lands at counter 0
        op(1, 0, 1, 1, 1, 1, 1, 4'd9, 9'h000, acc);   // right hold read at its counter 0
        chk("R11 right counter at 0", rdata_r, 9'h055);
        rd_load(0, 4'd0, "R11 left hold write at 0");
    endtask

    task automatic t_rw();
        wr_load(0, 4'd5, 9'h1A3);
        wr_load(0, 4'd9, 9'h0C4);
        rd_load(0, 4'd5, "R6 R2 read 5");
        rd_load(0, 4'd9, "R6 R2 read 9");
    endtask

    task automatic t_pipe();
        logic [AW-1:0] acc;
        pipe_l = 1;
        op(0, 1, 0, 1, 1, 1, 1, 4'd0, '0, acc);
        op(0, 0, 1, 0, 1, 1, 1, 4'd9, '0, acc);
        chk("R8 pipelined not yet valid", rvalid_l, 0);
        op(0, 1, 0, 1, 1, 1, 1, 4'd0, '0, acc);
        chk("R8 pipelined valid", rvalid_l, 1);
        chk("R8 pipelined data", rdata_l, shadow[9]);
        pipe_l = 0;
        op(0, 1, 0, 1, 1, 1, 1, 4'd0, '0, acc);
        chk("R8 flow-through lasts one cycle", rvalid_l, 0);
    endtask

    task automatic t_burst();
        logic [AW-1:0] acc;
        wr_load(0, 4'd14, 9'h111);
        op(0, 0, 1, 1, 0, 1, 0, 4'd0, 9'h122, acc);
        op(0, 0, 1, 1, 0, 1, 0, 4'd0, 9'h133, acc);
        chk("R3 wrap to zero", acc, 0);
        rd_load(0, 4'd15, "R3 step to 15");
        rd_load(0, 4'd0, "R3 wrap word");
        rd_load(0, 4'd14, "R3 burst start");
    endtask

    task automatic t_hold();
        logic [AW-1:0] acc;
        wr_load(0, 4'd3, 9'h0AB);
        op(0, 0, 1, 1, 1, 1, 1, 4'd12, '0, acc);
        chk("R5 hold read", rdata_l, 9'h0AB);
        op(0, 0, 1, 1, 1, 1, 1, 4'd12, '0, acc);
        chk("R5 hold again", rdata_l, 9'h0AB);
    endtask

    task automatic t_clear();
        logic [AW-1:0] acc;
        wr_load(0, 4'd7, 9'h077);
        op(0, 0, 1, 0, 0, 0, 1, 4'd9, '0, acc);
        chk("R4 clear beats load and step", rdata_l, 9'h133);
        op(0, 0, 1, 1, 1, 1, 1, 4'd9, '0, acc);
        chk("R4 counter left at zero", rdata_l, 9'h133);
    endtask

    task automatic t_desel();
        logic [AW-1:0] acc;
        op(0, 0, 0, 0, 1, 1, 0, 4'd5, 9'h1FF, acc);
        chk("R1 no output on deselected write", rvalid_l, 0);
        op(0, 1, 1, 0, 1, 1, 0, 4'd5, 9'h1EE, acc);
        rd_load(0, 4'd5, "R1 deselected write ignored");
        op(0, 1, 1, 0, 1, 1, 1, 4'd9, '0, acc);
        chk("R1 deselected read not valid", rvalid_l, 0);
        chk("R1 deselected read data", rdata_l, 0);
    endtask

    task automatic t_desel_cnt();
        logic [AW-1:0] acc;
        wr_load(0, 4'd11, 9'h0BB);
        wr_load(0, 4'd12, 9'h0CC);
        rd_load(0, 4'd2, "R10 setup");
        op(0, 1, 0, 0, 1, 1, 1, 4'd11, '0, acc);      // deselected load
        op(0, 0, 1, 1, 1, 1, 1, 4'd0, '0, acc);
        chk("R10 deselected load", rdata_l, 9'h0BB);
        op(0, 1, 0, 1, 0, 1, 1, 4'd0, '0, acc);       // deselected step
        op(0, 0, 1, 1, 1, 1, 1, 4'd0, '0, acc);
        chk("R10 deselected step", rdata_l, 9'h0CC);
    endtask

    task automatic t_oe();
        logic [AW-1:0] acc;
        oe_l_n = 1;
        op(0, 0, 1, 0, 1, 1, 1, 4'd5, '0, acc);
        chk("R7 oe high blocks valid", rvalid_l, 0);
        chk("R7 oe high data zero", rdata_l, 0);
        oe_l_n = 0;
        #0.5;
        chk("R7 oe low valid", rvalid_l, 1);
        chk("R7 oe low data", rdata_l, shadow[5]);
    endtask

    task automatic t_cross();
        wr_load(0, 4'd6, 9'h066);
        rd_load(1, 4'd6, "R9 left to right");
        wr_load(1, 4'd2, 9'h122);
        rd_load(0, 4'd2, "R9 right to left");
        wr_load(1, 4'd5, 9'h155);
        rd_load(0, 4'd5, "R9 right overwrites left word");
    endtask

    task automatic t_both();
        logic [AW-1:0] a0, a1;
        set_side(0, 0, 1, 0, 1, 1, 1, 4'd14, '0, a0);
        set_side(1, 0, 1, 0, 1, 1, 1, 4'd6, '0, a1);
        tick();
        chk("R9 same-edge left", rdata_l, shadow[a0]);
        chk("R9 same-edge right", rdata_r, shadow[a1]);
    endtask

    initial begin
        addr_l = '0; addr_r = '0; wdata_l = '0; wdata_r = '0;
        oe_l_n = 0; oe_r_n = 0; pipe_l = 0; pipe_r = 0;
        idle_all();
        cnt_m[0] = '0; cnt_m[1] = '0;
        for (int i = 0; i < (1 << AW); i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_rw();
        t_pipe();
        t_burst();
        t_hold();
        t_clear();
        t_desel();
        t_desel_cnt();
        t_oe();
        t_cross();
        t_both();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule